// File: doc/BRIEF.md
# SPI Controller Interrupt Register Set

This block is the interrupt section of an SPI controller. It collects seven event lines from the FIFOs and the serial engine. It presents them to software as a status register, and it gates them with a mask to drive one level-sensitive interrupt line. Software reaches it over a simple 32-bit register bus. Writes are single-cycle strobes. Read data is combinational from the address.

Some status bits are sticky latches that hold a one-cycle event until software clears them by writing a one to that bit. Others follow a FIFO level directly and cannot be cleared by software. The mask cannot be written directly. Software sets mask bits through a write-only enable register and clears them through a write-only disable register, and can read the mask back at its own offset. The interrupt output stays high while any pending status bit is also enabled.

All pins are plain control and status signals. There is no streaming data path, so no valid/ready handshake is used.

Top module: `spi_irq_regs`

## Requirements
- R1: After reset all mask bits and all sticky status bits are 0, and irq_o is low.
- R2: A write to offset 0x08 (enable) sets each mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R3: A write to offset 0x0C (disable) clears each mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R4: Offset 0x10 reads the mask in bits 6:0. Offsets 0x08 and 0x0C read as zero.
- R5: Bits 0 (RX overrun), 1 (mode fault), 2 (TX below watermark) and 6 (TX underflow) are sticky. An event that is high in a cycle sets the bit at the next clock edge, and the bit stays set until it is cleared.
- R6: A write to offset 0x04 (status) clears exactly the sticky bits whose data bit is 1.
- R7: If a sticky event and a clear of the same bit fall in the same cycle, the bit ends up set.
- R8: Bits 3 (TX full), 4 (RX not empty) and 5 (RX full) read as the current level of their event input. Writing ones to them at offset 0x04 has no effect.
- R9: irq_o is high exactly when the status bits ANDed with the mask bits are non-zero.
- R10: Data bits 31:7 of every write are ignored and read as 0. Writes to unmapped offsets change nothing, and unmapped offsets read 0. No write takes effect unless bus_sel and bus_wr are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 6 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| evt_i | input | 7 | Event inputs: pulses for sticky bits, levels for level bits |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench drives random mixes of event vectors and writes to every mapped offset and to unmapped ones. It compares status, mask, the written offset and the interrupt line against a reference model on every step. These random mixes separate sticky bits from level bits, and they show that the set and clear paths of the mask touch only the bits written with a one. Directed cases cover the reset state, an event that meets a clear of the same bit, write-one attempts on level bits, and writes with only upper data bits set. These cases tell the event-wins priority apart from the clear-wins priority, and they show that the level bits and the upper data bits take no part in a write.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int unsigned IRQ_BITS = 7;

  localparam int unsigned OFS_STATUS  = 'h04;
  localparam int unsigned OFS_ENABLE  = 'h08;
  localparam int unsigned OFS_DISABLE = 'h0C;
  localparam int unsigned OFS_MASK    = 'h10;

  localparam int unsigned BIT_RX_OVR   = 0;
  localparam int unsigned BIT_MODE_FLT = 1;
  localparam int unsigned BIT_TX_LOW   = 2;
  localparam int unsigned BIT_TX_FULL  = 3;
  localparam int unsigned BIT_RX_AVAIL = 4;
  localparam int unsigned BIT_RX_FULL  = 5;
  localparam int unsigned BIT_TX_UNDER = 6;

  localparam logic [IRQ_BITS-1:0] STICKY_DEFAULT = 7'b100_0111;

  typedef struct packed {
    logic stat_clr;
    logic mask_set;
    logic mask_clr;
  } wr_strobe_t;
endpackage

// File: rtl/spi_irq_bus_dec.sv
module spi_irq_bus_dec
  import spi_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NBITS  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NBITS-1:0]  status_i,
  input  logic [NBITS-1:0]  mask_i,
  output wr_strobe_t        strb_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_ENABLE  = ADDR_W'(OFS_ENABLE);
  localparam logic [ADDR_W-1:0] A_DISABLE = ADDR_W'(OFS_DISABLE);
  localparam logic [ADDR_W-1:0] A_MASK    = ADDR_W'(OFS_MASK);

  logic wr_go;
  assign wr_go = bus_sel & bus_wr;

  always_comb begin
    strb_o.stat_clr = wr_go && (bus_addr == A_STATUS);
    strb_o.mask_set = wr_go && (bus_addr == A_ENABLE);
    strb_o.mask_clr = wr_go && (bus_addr == A_DISABLE);
  end

  always_comb begin
    rdata_o = '0;
    if (bus_addr == A_STATUS)    rdata_o[NBITS-1:0] = status_i;
    else if (bus_addr == A_MASK) rdata_o[NBITS-1:0] = mask_i;
  end

  // R10: at most one register is written per cycle, and only under sel and wr
  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb_o.stat_clr, strb_o.mask_set, strb_o.mask_clr}));
  a_r10_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr) |-> (strb_o == '0));
endmodule

// File: rtl/spi_irq_mask.sv
module spi_irq_mask #(
  parameter int unsigned NBITS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic [NBITS-1:0] bits_i,
  output logic [NBITS-1:0] mask_o
);
  logic [NBITS-1:0] set_v, clr_v;
  assign set_v = set_en ? bits_i : '0;
  assign clr_v = clr_en ? bits_i : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) mask_o <= '0;
    else        mask_o <= (mask_o | set_v) & ~clr_v;
  end

  // R2: written ones become set, other bits hold
  a_r2_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((mask_o & $past(bits_i)) == $past(bits_i)) &&
               ((mask_o & ~$past(bits_i)) == ($past(mask_o) & ~$past(bits_i))));
  // R3: written ones become clear, other bits hold
  a_r3_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((mask_o & $past(bits_i)) == '0) &&
               ((mask_o & ~$past(bits_i)) == ($past(mask_o) & ~$past(bits_i))));
  a_r4_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !clr_en) |=> $stable(mask_o));
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status #(
  parameter int unsigned      NBITS       = 7,
  parameter logic [NBITS-1:0] STICKY_MASK = 7'b100_0111
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] evt_i,
  input  logic             clr_en,
  input  logic [NBITS-1:0] clr_bits_i,
  output logic [NBITS-1:0] status_o
);
  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    if (STICKY_MASK[i]) begin : g_sticky
      logic q;
      always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= (q & ~(clr_en & clr_bits_i[i])) | evt_i[i];
      end
      assign status_o[i] = q;

      // R5: a latched bit holds until a clear arrives
      a_r5_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !(clr_en && clr_bits_i[i])) |=> q);
      a_r5_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i[i] |=> q);
      // R6: a clear without a competing event empties the bit
      a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && clr_bits_i[i] && !evt_i[i]) |=> !q);
      // R7: event beats a simultaneous clear
      a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && clr_bits_i[i] && evt_i[i]) |=> q);
    end else begin : g_level
      assign status_o[i] = evt_i[i];
    end
  end
endmodule

// File: rtl/spi_irq_regs.sv
module spi_irq_regs
  import spi_irq_pkg::*;
#(
  parameter int unsigned      ADDR_W      = 6,
  parameter int unsigned      DATA_W      = 32,
  parameter int unsigned      NBITS       = IRQ_BITS,
  parameter logic [NBITS-1:0] STICKY_MASK = STICKY_DEFAULT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NBITS-1:0]  evt_i,
  output logic              irq_o
);
  wr_strobe_t       strb;
  logic [NBITS-1:0] status, mask, wbits;
  logic             unused_hi;

  assign wbits     = bus_wdata[NBITS-1:0];
  assign unused_hi = ^bus_wdata[DATA_W-1:NBITS];

  spi_irq_bus_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NBITS(NBITS)) u_dec (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .status_i(status), .mask_i(mask),
    .strb_o(strb), .rdata_o(bus_rdata)
  );

  spi_irq_mask #(.NBITS(NBITS)) u_mask (
    .clk(clk), .rst_n(rst_n), .set_en(strb.mask_set), .clr_en(strb.mask_clr),
    .bits_i(wbits), .mask_o(mask)
  );

  spi_irq_status #(.NBITS(NBITS), .STICKY_MASK(STICKY_MASK)) u_stat (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_en(strb.stat_clr),
    .clr_bits_i(wbits), .status_o(status)
  );

  assign irq_o = |(status & mask);

  // R9: with nothing enabled the line stays quiet
  a_r9_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq_o);
  // R1: the cycle after reset nothing is enabled
  a_r1_reset_clean: assert property (@(posedge clk)
    !rst_n |=> (mask == '0));
endmodule

// File: tb/test_spi_irq_regs.sv
`timescale 1ns/100ps
module test_spi_irq_regs;
  localparam logic [6:0] STICKY = 7'b100_0111;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [6:0]  evt = '0;
  logic        irq_o;

  int errors = 0, checks = 0, cycles = 0;
  logic [6:0] m_sticky = '0, m_mask = '0;

  always #2 clk = ~clk;

  spi_irq_regs i_spi_irq_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_i(evt), .irq_o(irq_o)
  );

  function automatic logic [6:0] m_status(input logic [6:0] e);
    return m_sticky | (e & ~STICKY);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [5:0] a, input logic [6:0] e);
    if (a == 6'h04) return {25'd0, m_status(e)};
    if (a == 6'h10) return {25'd0, m_mask};
    return 32'd0;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(input bit wr, input logic [5:0] a, input logic [31:0] d,
                      input logic [6:0] e, input string req);
    @(negedge clk);
    bus_sel = wr; bus_wr = wr; bus_addr = a; bus_wdata = d; evt = e;
    @(posedge clk);
    if (wr && a == 6'h04) m_sticky = m_sticky & ~d[6:0];
    m_sticky = m_sticky | (e & STICKY);
    if (wr && a == 6'h08) m_mask = m_mask | d[6:0];
    if (wr && a == 6'h0C) m_mask = m_mask & ~d[6:0];
    #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = 6'h04; #0.3;
    chk({req, " status"}, bus_rdata, exp_rd(6'h04, e));
    bus_addr = 6'h10; #0.3;
    chk({req, " mask"}, bus_rdata, exp_rd(6'h10, e));
    chk({req, " R9 irq"}, {31'd0, irq_o}, {31'd0, |(m_status(e) & m_mask)});
    bus_addr = a; #0.3;
    chk({req, " R4/R10 read"}, bus_rdata, exp_rd(a, e));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog: got %0d cycles expected under 100000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    #0.5; chk("R1 status", bus_rdata, 32'd0);
    bus_addr = 6'h10; #0.3; chk("R1 mask", bus_rdata, 32'd0);
    chk("R1 irq", {31'd0, irq_o}, 32'd0);

    step(1, 6'h08, 32'h12, 7'h00, "R2 enable");
    step(1, 6'h08, 32'h04, 7'h00, "R2 keep others");
    step(1, 6'h0C, 32'h10, 7'h00, "R3 disable");
    step(0, 6'h00, 32'h0,  7'h02, "R5 mode fault event");
    step(0, 6'h00, 32'h0,  7'h00, "R5 sticky hold");
    step(1, 6'h04, 32'h02, 7'h02, "R7 event wins");
    step(1, 6'h04, 32'h06, 7'h00, "R6 clear ones");
    step(1, 6'h04, 32'h38, 7'h38, "R8 level not cleared");
    step(0, 6'h00, 32'h0,  7'h00, "R8 level follows");
    step(1, 6'h08, 32'hFFFF_FF80, 7'h00, "R10 upper bits");
    step(1, 6'h14, 32'h7F, 7'h00, "R10 unmapped write");
    step(0, 6'h08, 32'h7F, 7'h00, "R10 no strobe");
    step(1, 6'h0C, 32'h7F, 7'h00, "R3 disable all");

    for (int n = 0; n < 400; n++) begin
      logic [5:0] a;
      logic [6:0] e;
      case ($urandom % 6)
        0: a = 6'h04; 1: a = 6'h08; 2: a = 6'h0C;
        3: a = 6'h10; 4: a = 6'h14; default: a = 6'h00;
      endcase
      e = 7'($urandom) & 7'($urandom);
      step(($urandom % 3) != 0, a, $urandom, e, "R2/R3/R5/R6 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule